// File: doc/BRIEF.md
# Windowed Indexed-Pixel Video Scanout

This block produces a raster video stream from a byte-per-pixel framebuffer held in a 32-bit-wide video memory. Free-running horizontal and vertical counters, whose visible, front-porch, sync and back-porch lengths are parameters, generate the sync and data-enable outputs. A one-cycle frame-end pulse marks the last position of every frame. During visible video the block computes a memory read address for every pixel. One clock later it takes the returned word, selects the addressed byte lane and drives that byte unchanged onto red, green and blue.

Three 64-bit control words are sampled live. The framebuffer word gives the base address, the row width in units of 64 pixels, and the pixel format. The window word gives the window origin, size, and horizontal and vertical magnification. Bit 0 of the mode word enables colour output. Pixels outside the window, or outside the visible area, are black. Each window pixel is mapped back to a stored pixel by dividing its offset from the window origin by the magnification factor. All three words are sampled together at the clock edge that captures a pixel, so one pixel never mixes old and new settings.

Top module: `idx8_scanout`

## Requirements
- R1: With default polarity, hsync is high for horizontal positions H_VIS+H_FP up to (but excluding) H_VIS+H_FP+H_SW, and vsync is high on the matching lines. de is high exactly for positions with h < H_VIS and v < V_VIS. Each output reflects the counter position of the previous clock, so the first clock edge after reset release shows position (0,0).
- R2: frame_end is high for exactly one cycle per frame, on the output cycle of the last position (h = total-1, v = total-1).
- R3: For a visible pixel inside the window, with the block enabled and the format valid, r, g and b all equal the fetched byte.
- R4: A visible pixel is inside the window when X0 ≤ h ≤ X0+WM1 and Y0 ≤ v ≤ Y0+HM1. Every other pixel, and every non-visible position, has r = g = b = 0, while de still follows R1.
- R5: The stored column is (h−X0)/(HMAG+1) and the stored row is (v−Y0)/(VMAG+1). The window word fields are X0 [11:0], Y0 [22:12], HMAG [26:23], VMAG [28:27], WM1 [43:32] and HM1 [54:44].
- R6: The byte address is BASE×8192 + row×(FBW×64) + column. BASE is framebuffer word bits [8:0] and FBW is bits [14:9]. vram_raddr carries this address with bits [1:0] cleared, and is answered by vram_rdata one clock later. Address bits [1:0] pick the byte lane little-endian: 0 selects rdata[7:0] and 3 selects rdata[31:24].
- R7: While mode word bit 0 is 0, the colour outputs are 0 and the timing continues.
- R8: Colour is output only when framebuffer word bits [19:15] equal 5'h13. Any other value gives black.
- R9: While rst_n is low, the counters are held at zero and hsync, vsync, de, frame_end, r, g and b are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | 64 | Bit 0 enables colour output |
| fb_word | input | 64 | Framebuffer base, row width, pixel format |
| win_word | input | 64 | Window origin, size, magnification |
| vram_raddr | output | ADDR_W | Word-aligned byte address of the pixel being fetched |
| vram_rdata | input | 32 | Memory word, one clock after the address |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable, visible area |
| r | output | 8 | Red |
| g | output | 8 | Green |
| b | output | 8 | Blue |
| frame_end | output | 1 | One-cycle pulse on the last position of a frame |

## Verification
Every output is due one clock after the counter position it describes. The memory answers the address it sees at an edge with data valid after that same edge. The reference model therefore evaluates the position and the live control words at each rising edge, and compares all outputs at the following falling edge. The byte pattern in memory is a function of the byte address, so a wrong lane, row stride, base or divisor shows up as a colour mismatch. Scenarios cover the disabled state, several window and magnification settings, a window running off the visible area, an invalid format, a control change in mid-frame and a reset in mid-frame.

// File: rtl/idx8_scanout_pkg.sv
package idx8_scanout_pkg;

   localparam logic [4:0] FMT_IDX8   = 5'h13;
   localparam int         BASE_SHIFT = 13;
   localparam int         ROW_SHIFT  = 6;
   localparam int         XW         = 12;
   localparam int         YW         = 11;

   typedef struct packed {
      logic [8:0] base;
      logic [5:0] fbw;
      logic [4:0] fmt;
   } fb_cfg_t;

   typedef struct packed {
      logic [XW-1:0] x0;
      logic [YW-1:0] y0;
      logic [3:0]    hmag;
      logic [1:0]    vmag;
      logic [XW-1:0] wm1;
      logic [YW-1:0] hm1;
   } win_cfg_t;

endpackage

// File: rtl/scan_timing.sv
module scan_timing #(
   parameter int H_VIS = 16,
   parameter int H_FP  = 2,
   parameter int H_SW  = 3,
   parameter int H_BP  = 2,
   parameter int V_VIS = 8,
   parameter int V_FP  = 1,
   parameter int V_SW  = 2,
   parameter int V_BP  = 1,
   parameter int HCW   = 5,
   parameter int VCW   = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   output logic [HCW-1:0] hcnt,
   output logic [VCW-1:0] vcnt,
   output logic           act,
   output logic           hs_raw,
   output logic           vs_raw,
   output logic           last
);
   localparam int HT = H_VIS + H_FP + H_SW + H_BP;
   localparam int VT = V_VIS + V_FP + V_SW + V_BP;
   localparam logic [HCW-1:0] H_LAST = HCW'(HT - 1);
   localparam logic [VCW-1:0] V_LAST = VCW'(VT - 1);
   localparam logic [HCW-1:0] H_VIS_C = HCW'(H_VIS);
   localparam logic [VCW-1:0] V_VIS_C = VCW'(V_VIS);
   localparam logic [HCW-1:0] HS_BEG = HCW'(H_VIS + H_FP);
   localparam logic [HCW-1:0] HS_END = HCW'(H_VIS + H_FP + H_SW);
   localparam logic [VCW-1:0] VS_BEG = VCW'(V_VIS + V_FP);
   localparam logic [VCW-1:0] VS_END = VCW'(V_VIS + V_FP + V_SW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (hcnt == H_LAST) begin
         hcnt <= '0;
         vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   always_comb begin
      act    = (hcnt < H_VIS_C) && (vcnt < V_VIS_C);
      hs_raw = (hcnt >= HS_BEG) && (hcnt < HS_END);
      vs_raw = (vcnt >= VS_BEG) && (vcnt < VS_END);
      last   = (hcnt == H_LAST) && (vcnt == V_LAST);
   end

   p_hcnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hcnt <= H_LAST);
   p_vcnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      vcnt <= V_LAST);
   p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hcnt == H_LAST) |=> (hcnt == '0));

endmodule

// File: rtl/scan_fetch.sv
module scan_fetch
   import idx8_scanout_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int HCW    = 5,
   parameter int VCW    = 4
) (
   input  logic [HCW-1:0]    hcnt,
   input  logic [VCW-1:0]    vcnt,
   input  fb_cfg_t           fb,
   input  win_cfg_t          win,
   output logic [ADDR_W-1:0] raddr,
   output logic [1:0]        lane,
   output logic              inwin
);
   logic [XW:0]       hx, x0e, xend;
   logic [YW:0]       vy, y0e, yend;
   logic [XW-1:0]     relx, col, hdiv;
   logic [YW-1:0]     rely, row, vdiv;
   logic [ADDR_W-1:0] byte_addr;

   always_comb begin
      hx   = (XW+1)'(hcnt);
      vy   = (YW+1)'(vcnt);
      x0e  = {1'b0, win.x0};
      y0e  = {1'b0, win.y0};
      xend = x0e + {1'b0, win.wm1};
      yend = y0e + {1'b0, win.hm1};
      inwin = (hx >= x0e) && (hx <= xend) && (vy >= y0e) && (vy <= yend);
      relx = XW'(hx - x0e);
      rely = YW'(vy - y0e);
      hdiv = XW'(win.hmag) + XW'(1);
      vdiv = YW'(win.vmag) + YW'(1);
      col  = relx / hdiv;
      row  = rely / vdiv;
      byte_addr = (ADDR_W'(fb.base) << BASE_SHIFT)
                + ADDR_W'(row) * (ADDR_W'(fb.fbw) << ROW_SHIFT)
                + ADDR_W'(col);
      raddr = {byte_addr[ADDR_W-1:2], 2'b00};
      lane  = byte_addr[1:0];
   end

endmodule

// File: rtl/scan_out.sv
module scan_out #(
   parameter bit SYNC_ACTIVE_LOW = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        act,
   input  logic        hs_raw,
   input  logic        vs_raw,
   input  logic        last,
   input  logic        show,
   input  logic [1:0]  lane,
   input  logic [31:0] rdata,
   output logic        hsync,
   output logic        vsync,
   output logic        de,
   output logic        frame_end,
   output logic [7:0]  pix
);
   logic       act_q, hs_q, vs_q, eof_q, show_q;
   logic [1:0] lane_q;
   logic [7:0] lanes [4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         hs_q   <= 1'b0;
         vs_q   <= 1'b0;
         eof_q  <= 1'b0;
         show_q <= 1'b0;
         lane_q <= 2'd0;
      end else begin
         act_q  <= act;
         hs_q   <= hs_raw;
         vs_q   <= vs_raw;
         eof_q  <= last;
         show_q <= show;
         lane_q <= lane;
      end
   end

   for (genvar i = 0; i < 4; i++) begin : g_lane
      assign lanes[i] = rdata[8*i +: 8];
   end

   assign pix       = show_q ? lanes[lane_q] : 8'd0;
   assign de        = act_q;
   assign frame_end = eof_q;

   if (SYNC_ACTIVE_LOW) begin : g_sync_low
      assign hsync = rst_n ? ~hs_q : 1'b0;
      assign vsync = rst_n ? ~vs_q : 1'b0;
   end else begin : g_sync_high
      assign hsync = hs_q;
      assign vsync = vs_q;
   end

   p_de_no_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> (!hs_q && !vs_q));
   p_eof_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eof_q |=> !eof_q);
   p_eof_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eof_q |-> !act_q);
   p_blank_black_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !act_q |-> (pix == 8'd0));

endmodule

// File: rtl/idx8_scanout.sv
module idx8_scanout
   import idx8_scanout_pkg::*;
#(
   parameter int H_VIS  = 16,
   parameter int H_FP   = 2,
   parameter int H_SW   = 3,
   parameter int H_BP   = 2,
   parameter int V_VIS  = 8,
   parameter int V_FP   = 1,
   parameter int V_SW   = 2,
   parameter int V_BP   = 1,
   parameter int ADDR_W = 32,
   parameter bit SYNC_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [63:0]       mode_word,
   input  logic [63:0]       fb_word,
   input  logic [63:0]       win_word,
   output logic [ADDR_W-1:0] vram_raddr,
   input  logic [31:0]       vram_rdata,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [7:0]        r,
   output logic [7:0]        g,
   output logic [7:0]        b,
   output logic              frame_end
);
   localparam int HT  = H_VIS + H_FP + H_SW + H_BP;
   localparam int VT  = V_VIS + V_FP + V_SW + V_BP;
   localparam int HCW = $clog2(HT);
   localparam int VCW = $clog2(VT);

   if (H_VIS < 1 || H_FP < 1 || H_SW < 1 || H_BP < 1) begin : g_bad_h
      $error("horizontal interval lengths must all be at least 1");
   end
   if (V_VIS < 1 || V_FP < 1 || V_SW < 1 || V_BP < 1) begin : g_bad_v
      $error("vertical interval lengths must all be at least 1");
   end
   if (HT > 4096 || VT > 2048) begin : g_bad_total
      $error("raster totals exceed the window coordinate range");
   end
   if (ADDR_W < 24) begin : g_bad_addr
      $error("ADDR_W must be at least 24 to hold the largest byte address");
   end

   fb_cfg_t        fb;
   win_cfg_t       win;
   logic [HCW-1:0] hcnt;
   logic [VCW-1:0] vcnt;
   logic           act, hs_raw, vs_raw, last, inwin, show;
   logic [1:0]     lane;
   logic [7:0]     pix;
   wire            unused_cfg = ^{mode_word[63:1], fb_word[63:20],
                                  win_word[63:55], win_word[31:29]};

   assign fb.base  = fb_word[8:0];
   assign fb.fbw   = fb_word[14:9];
   assign fb.fmt   = fb_word[19:15];
   assign win.x0   = win_word[11:0];
   assign win.y0   = win_word[22:12];
   assign win.hmag = win_word[26:23];
   assign win.vmag = win_word[28:27];
   assign win.wm1  = win_word[43:32];
   assign win.hm1  = win_word[54:44];

   scan_timing #(
      .H_VIS(H_VIS), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
      .V_VIS(V_VIS), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
      .HCW(HCW), .VCW(VCW)
   ) i_timing (
      .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
      .act(act), .hs_raw(hs_raw), .vs_raw(vs_raw), .last(last)
   );

   scan_fetch #(.ADDR_W(ADDR_W), .HCW(HCW), .VCW(VCW)) i_fetch (
      .hcnt(hcnt), .vcnt(vcnt), .fb(fb), .win(win),
      .raddr(vram_raddr), .lane(lane), .inwin(inwin)
   );

   assign show = act && inwin && mode_word[0] && (fb.fmt == FMT_IDX8);

   scan_out #(.SYNC_ACTIVE_LOW(SYNC_ACTIVE_LOW)) i_out (
      .clk(clk), .rst_n(rst_n), .act(act), .hs_raw(hs_raw), .vs_raw(vs_raw),
      .last(last), .show(show), .lane(lane), .rdata(vram_rdata),
      .hsync(hsync), .vsync(vsync), .de(de), .frame_end(frame_end), .pix(pix)
   );

   assign r = pix;
   assign g = pix;
   assign b = pix;

   p_disabled_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mode_word[0]) |-> (r == 8'd0 && g == 8'd0 && b == 8'd0));
   p_fmt_black_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fb_word[19:15]) != FMT_IDX8) |-> (r == 8'd0));
   p_reset_quiet_r9: assert property (@(posedge clk)
      !rst_n |-> (!de && !frame_end && r == 8'd0));

endmodule

// File: tb/test_idx8_scanout.sv
`timescale 1ns/1ps
module test_idx8_scanout;
   localparam int H_VIS = 16, H_FP = 2, H_SW = 3, H_BP = 2;
   localparam int V_VIS = 8,  V_FP = 1, V_SW = 2, V_BP = 1;
   localparam int HT = H_VIS + H_FP + H_SW + H_BP;
   localparam int VT = V_VIS + V_FP + V_SW + V_BP;
   localparam int FRAME = HT * VT;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] mode_word = '0, fb_word = '0, win_word = '0;
   logic [31:0] vram_raddr;
   logic [31:0] vram_rdata = '0;
   logic        hsync, vsync, de, frame_end;
   logic [7:0]  r, g, b;

   always #2.5 clk = ~clk;

   idx8_scanout #(
      .H_VIS(H_VIS), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
      .V_VIS(V_VIS), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
   ) i_idx8_scanout (
      .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .fb_word(fb_word),
      .win_word(win_word), .vram_raddr(vram_raddr), .vram_rdata(vram_rdata),
      .hsync(hsync), .vsync(vsync), .de(de), .r(r), .g(g), .b(b),
      .frame_end(frame_end)
   );

   function automatic logic [7:0] pat(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]};
   endfunction

   // memory: one-clock read latency, contents a function of byte address
   always @(posedge clk)
      vram_rdata <= {pat(vram_raddr + 3), pat(vram_raddr + 2),
                     pat(vram_raddr + 1), pat(vram_raddr)};

   int tests = 0, fails = 0, cycles = 0;
   bit done = 1'b0;

   // reference model
   int mh = 0, mv = 0;
   bit e_de = 0, e_hs = 0, e_vs = 0, e_eof = 0;
   logic [7:0] e_pix = '0;
   string tag = "R9";

   always @(posedge clk) begin
      if (!rst_n) begin
         mh = 0; mv = 0;
         e_de = 0; e_hs = 0; e_vs = 0; e_eof = 0; e_pix = 0; tag = "R9";
      end else begin
         int dx, dy, mgh, mgv, dw, dh, base, fbw, col, row;
         bit inw;
         dx  = int'(win_word[11:0]);  dy  = int'(win_word[22:12]);
         mgh = int'(win_word[26:23]); mgv = int'(win_word[28:27]);
         dw  = int'(win_word[43:32]); dh  = int'(win_word[54:44]);
         base = int'(fb_word[8:0]);   fbw = int'(fb_word[14:9]);
         e_de  = (mh < H_VIS) && (mv < V_VIS);
         e_hs  = (mh >= H_VIS + H_FP) && (mh < H_VIS + H_FP + H_SW);
         e_vs  = (mv >= V_VIS + V_FP) && (mv < V_VIS + V_FP + V_SW);
         e_eof = (mh == HT - 1) && (mv == VT - 1);
         inw = (mh >= dx) && (mh <= dx + dw) && (mv >= dy) && (mv <= dy + dh);
         e_pix = 0;
         if (!e_de) tag = "R4";
         else if (!mode_word[0]) tag = "R7";
         else if (fb_word[19:15] != 5'h13) tag = "R8";
         else if (!inw) tag = "R4";
         else begin
            col = (mh - dx) / (mgh + 1);
            row = (mv - dy) / (mgv + 1);
            e_pix = pat(32'(base * 8192 + row * fbw * 64 + col));
            tag = (mgh != 0 || mgv != 0) ? "R5 R6" : "R3 R6";
         end
         if (mh == HT - 1) begin
            mh = 0;
            mv = (mv == VT - 1) ? 0 : mv + 1;
         end else mh = mh + 1;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
                  req, what, cycles, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            chk("R9", "de",    8'(de),    8'd0);
            chk("R9", "hsync", 8'(hsync), 8'd0);
            chk("R9", "vsync", 8'(vsync), 8'd0);
            chk("R9", "eof",   8'(frame_end), 8'd0);
            chk("R9", "r",     r, 8'd0);
         end else begin
            chk("R1", "de",    8'(de),    8'(e_de));
            chk("R1", "hsync", 8'(hsync), 8'(e_hs));
            chk("R1", "vsync", 8'(vsync), 8'(e_vs));
            chk("R2", "frame_end", 8'(frame_end), 8'(e_eof));
            chk(tag, "r", r, e_pix);
            chk(tag, "g", g, e_pix);
            chk(tag, "b", b, e_pix);
         end
      end
   end

   function automatic logic [63:0] mkwin(int dx, int dy, int mgh, int mgv,
                                         int wm1, int hm1);
      return {9'd0, 11'(hm1), 12'(wm1), 3'd0, 2'(mgv), 4'(mgh), 11'(dy), 12'(dx)};
   endfunction

   function automatic logic [63:0] mkfb(int base, int fbw, int fmt);
      return {44'd0, 5'(fmt), 6'(fbw), 9'(base)};
   endfunction

   task automatic setcfg(input logic [63:0] m, input logic [63:0] f,
                         input logic [63:0] w);
      @(negedge clk);
      mode_word = m; fb_word = f; win_word = w;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      // R9: reset state
      setcfg(64'd0, mkfb(0, 1, 5'h13), mkwin(4, 2, 1, 0, 7, 3));
      repeat (5) @(negedge clk);
      @(posedge clk); #1 rst_n = 1'b1;
      // R7: disabled for a frame
      repeat (FRAME) @(negedge clk);
      // R3 R5 R6: 2x horizontal window
      setcfg(64'd1, mkfb(0, 1, 5'h13), mkwin(4, 2, 1, 0, 7, 3));
      repeat (2 * FRAME) @(negedge clk);
      // R5 R6: 3x by 2x, nonzero base and wider rows
      setcfg(64'd1, mkfb(1, 2, 5'h13), mkwin(1, 1, 2, 1, 12, 5));
      repeat (2 * FRAME) @(negedge clk);
      // R4: window running off the visible area
      setcfg(64'd1, mkfb(2, 3, 5'h13), mkwin(10, 5, 0, 0, 20, 9));
      repeat (FRAME) @(negedge clk);
      // R3 R6: full screen, every byte lane, 4x vertical
      setcfg(64'd1, mkfb(0, 1, 5'h13), mkwin(0, 0, 0, 3, 15, 7));
      repeat (FRAME + 37) @(negedge clk);
      // mid-frame change of window
      setcfg(64'd1, mkfb(0, 1, 5'h13), mkwin(3, 0, 3, 2, 11, 6));
      repeat (FRAME) @(negedge clk);
      // R8: invalid format
      setcfg(64'd1, mkfb(0, 1, 5'h00), mkwin(0, 0, 0, 0, 15, 7));
      repeat (FRAME) @(negedge clk);
      // R9: reset in mid-frame, then restart from position (0,0)
      setcfg(64'd1, mkfb(0, 1, 5'h13), mkwin(2, 1, 1, 1, 9, 5));
      repeat (FRAME / 2) @(negedge clk);
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (FRAME + 5) @(negedge clk);
      finish_run();
   end
endmodule